// File: doc/BRIEF.md
# Bit-Position Table Address Generator

This block serves one vertical slice of a RAM-emulated ternary lookup table. It stores a bitmap in which every possible binary value of a short search subword owns one bit. It also stores a per-row offset register. When a subword is looked up, the block reports whether that value was mapped. It also returns the row of the downstream address-position table that belongs to that value.

The address is rank-compressed rather than read directly. The upper bits of the subword choose a bitmap row, and the lower bits choose a bit inside it. The block counts the set bits of that row from bit 0 up to and including the chosen bit, then adds the row's stored offset.

Mapping software fills the bitmap rows and offsets while a mapping-mode input is high. With each offset equal to the number of set bits in all lower rows minus one, the mapped values receive dense addresses starting at zero. Lookups are registered and return their result one clock later.

Top module: `bpt_addr_gen`

## Requirements
- R1: A synchronous reset clears res_valid, clears every bitmap bit, and sets every row offset to all ones (minus one in SUB_W+1-bit two's complement).
- R2: The key bits [SUB_W-1:POS_W] select the bitmap row, and the key bits [POS_W-1:0] select the bit position within that row.
- R3: res_hit is 1 exactly when the selected bit of the selected row is set.
- R4: When res_hit is 1, res_addr equals the number of set bits in the selected row at positions 0 to the selected position inclusive, plus that row's offset, taken modulo 2^(SUB_W+1).
- R5: Row writes (bm_we) and offset writes (li_we) take effect only in a cycle where map_en is 1. Otherwise they change nothing.
- R6: res_valid is 1 in exactly the cycle after a cycle with lk_valid high. res_hit and res_addr keep their values in cycles that follow a cycle without lk_valid.
- R7: A lookup in the same cycle as a write to the row it reads returns the contents from before that write. The next lookup sees the new contents.
- R8: With offsets programmed as prefix counts minus one, the mapped keys taken in ascending order receive addresses 0, 1, 2, … with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_en | input | 1 | Mapping mode; enables writes |
| bm_we | input | 1 | Bitmap row write strobe |
| bm_row | input | SUB_W-POS_W | Bitmap row to write |
| bm_data | input | 2^POS_W | Bitmap row contents |
| li_we | input | 1 | Row offset write strobe |
| li_row | input | SUB_W-POS_W | Row whose offset is written |
| li_data | input | SUB_W+1 | Offset value |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | SUB_W | Search subword |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Subword is mapped |
| res_addr | output | SUB_W+1 | Address-position table row, meaningful only with res_hit |

## Verification
A lookup and a mapping write can land in the same clock edge, and both can target the same row. The bench provokes this by raising bm_we, together with map_en, in the cycle that carries lk_valid for a key in the row being rewritten. The result is judged against the bench's record of the bitmap before the write. A second lookup of the same key must then reflect the new row, so stale data and write bypass are each caught.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  localparam int DEF_SUB_W = 8;
  localparam int DEF_POS_W = 4;
endpackage

// File: rtl/bpt_bitmap_store.sv
module bpt_bitmap_store #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 16,
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ROW_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ROW_W-1:0] rd_data
);
  logic [ROW_W-1:0] rows_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        rows_q[r] <= '0;
      else if (we && (wr_idx == IDX_W'(r)))
        rows_q[r] <= wr_data;
    end
  end

  assign rd_data = rows_q[rd_idx];
endmodule

// File: rtl/bpt_last_index_regs.sv
module bpt_last_index_regs #(
  parameter int ROWS = 16,
  parameter int LI_W = 9,
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LI_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [LI_W-1:0]  rd_data
);
  logic [LI_W-1:0] li_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_li
    always_ff @(posedge clk) begin
      if (rst)
        li_q[r] <= '1;
      else if (we && (wr_idx == IDX_W'(r)))
        li_q[r] <= wr_data;
    end
  end

  assign rd_data = li_q[rd_idx];
endmodule

// File: rtl/bpt_rank_counter.sv
module bpt_rank_counter #(
  parameter int POS_W = 4,
  localparam int ROW_W = 1 << POS_W,
  localparam int CNT_W = POS_W + 1
) (
  input  logic [ROW_W-1:0] row,
  input  logic [POS_W-1:0] pos,
  output logic [CNT_W-1:0] cnt,
  output logic             bit_set
);
  logic [ROW_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < ROW_W; i++)
      mask[i] = (i <= int'(pos));
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < ROW_W; i++)
      cnt = cnt + CNT_W'(row[i] & mask[i]);
  end

  assign bit_set = row[pos];
endmodule

// File: rtl/bpt_addr_gen.sv
module bpt_addr_gen #(
  parameter int SUB_W = bpt_pkg::DEF_SUB_W,
  parameter int POS_W = bpt_pkg::DEF_POS_W,
  localparam int ROW_SEL_W = SUB_W - POS_W,
  localparam int ROWS      = 1 << ROW_SEL_W,
  localparam int ROW_W     = 1 << POS_W,
  localparam int LI_W      = SUB_W + 1,
  localparam int CNT_W     = POS_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 map_en,
  input  logic                 bm_we,
  input  logic [ROW_SEL_W-1:0] bm_row,
  input  logic [ROW_W-1:0]     bm_data,
  input  logic                 li_we,
  input  logic [ROW_SEL_W-1:0] li_row,
  input  logic [LI_W-1:0]      li_data,
  input  logic                 lk_valid,
  input  logic [SUB_W-1:0]     lk_key,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic [LI_W-1:0]      res_addr
);
  logic [ROW_SEL_W-1:0] key_row;
  logic [POS_W-1:0]     key_pos;
  logic [ROW_W-1:0]     rd_row;
  logic [LI_W-1:0]      rd_li;
  logic [CNT_W-1:0]     rank_cnt;
  logic                 rank_bit;
  logic [LI_W-1:0]      sum;

  assign key_row = lk_key[SUB_W-1:POS_W];
  assign key_pos = lk_key[POS_W-1:0];

  bpt_bitmap_store #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bitmap (
    .clk     (clk),
    .rst     (rst),
    .we      (map_en & bm_we),
    .wr_idx  (bm_row),
    .wr_data (bm_data),
    .rd_idx  (key_row),
    .rd_data (rd_row)
  );

  bpt_last_index_regs #(.ROWS(ROWS), .LI_W(LI_W)) u_li (
    .clk     (clk),
    .rst     (rst),
    .we      (map_en & li_we),
    .wr_idx  (li_row),
    .wr_data (li_data),
    .rd_idx  (key_row),
    .rd_data (rd_li)
  );

  bpt_rank_counter #(.POS_W(POS_W)) u_rank (
    .row     (rd_row),
    .pos     (key_pos),
    .cnt     (rank_cnt),
    .bit_set (rank_bit)
  );

  assign sum = rd_li + LI_W'(rank_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_addr  <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit  <= rank_bit;
        res_addr <= sum;
      end
    end
  end
endmodule

// File: rtl/bpt_addr_gen_chk.sv
module bpt_addr_gen_chk #(
  parameter int SUB_W = 8,
  parameter int POS_W = 4,
  localparam int ROW_W = 1 << POS_W,
  localparam int LI_W  = SUB_W + 1,
  localparam int CNT_W = POS_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             map_en,
  input logic             lk_valid,
  input logic [SUB_W-1:0] lk_key,
  input logic             res_valid,
  input logic             res_hit,
  input logic [LI_W-1:0]  res_addr,
  input logic [ROW_W-1:0] rd_row,
  input logic [CNT_W-1:0] cnt,
  input logic             bit_set
);
  a_r1_reset_clears_valid: assert property (@(posedge clk) rst |=> !res_valid);

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);

  a_r6_hold_result: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> ($stable(res_hit) && $stable(res_addr)));

  a_r3_hit_implies_rank: assert property (@(posedge clk) disable iff (rst)
    bit_set |-> (cnt != '0));

  a_r5_no_write_outside_map: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(map_en) && $stable(lk_key)) |-> $stable(rd_row));
endmodule

bind bpt_addr_gen bpt_addr_gen_chk #(.SUB_W(SUB_W), .POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .map_en    (map_en),
  .lk_valid  (lk_valid),
  .lk_key    (lk_key),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_addr  (res_addr),
  .rd_row    (rd_row),
  .cnt       (rank_cnt),
  .bit_set   (rank_bit)
);

// File: tb/sim_bpt_addr_gen.sv
`timescale 1ns/1ps
module sim_bpt_addr_gen;
  localparam int W    = 8;
  localparam int P    = 4;
  localparam int RS   = W - P;
  localparam int ROWS = 1 << RS;
  localparam int RW   = 1 << P;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          map_en = 1'b0, bm_we = 1'b0, li_we = 1'b0, lk_valid = 1'b0;
  logic [RS-1:0] bm_row = '0, li_row = '0;
  logic [RW-1:0] bm_data = '0;
  logic [W:0]    li_data = '0;
  logic [W-1:0]  lk_key = '0;
  logic          res_valid, res_hit;
  logic [W:0]    res_addr;

  int n_tests = 0;
  int n_fail  = 0;
  logic [RW-1:0] m_bm [ROWS];
  logic [W:0]    m_li [ROWS];

  always #2.5 clk = ~clk;

  bpt_addr_gen #(.SUB_W(W), .POS_W(P)) u0 (
    .clk(clk), .rst(rst), .map_en(map_en), .bm_we(bm_we), .bm_row(bm_row),
    .bm_data(bm_data), .li_we(li_we), .li_row(li_row), .li_data(li_data),
    .lk_valid(lk_valid), .lk_key(lk_key), .res_valid(res_valid),
    .res_hit(res_hit), .res_addr(res_addr)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr(logic [W-1:0] key);
    int r = int'(key[W-1:P]);
    int c = 0;
    for (int i = 0; i <= int'(key[P-1:0]); i++) c += int'(m_bm[r][i]);
    return int'((m_li[r] + (W+1)'(c)) & {(W+1){1'b1}});
  endfunction

  task automatic wr_row(logic [RS-1:0] r, logic [RW-1:0] d, logic en);
    @(negedge clk);
    map_en = en; bm_we = 1'b1; bm_row = r; bm_data = d;
    @(negedge clk);
    map_en = 1'b0; bm_we = 1'b0;
    if (en) m_bm[r] = d;
  endtask

  task automatic wr_li(logic [RS-1:0] r, logic [W:0] d, logic en);
    @(negedge clk);
    map_en = en; li_we = 1'b1; li_row = r; li_data = d;
    @(negedge clk);
    map_en = 1'b0; li_we = 1'b0;
    if (en) m_li[r] = d;
  endtask

  task automatic lookup(logic [W-1:0] k);
    @(negedge clk);
    lk_valid = 1'b1; lk_key = k;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 res_valid after reset", int'(res_valid), 0);
    lookup(8'h00);
    check("R1 empty bitmap key 00", int'(res_hit), 0);
    lookup(8'hFF);
    check("R1 empty bitmap key FF", int'(res_hit), 0);
  endtask

  task automatic t_default_offset();
    wr_row(4'd3, 16'h0005, 1'b1);
    lookup(8'h32);
    check("R3 hit row3 pos2", int'(res_hit), 1);
    check("R1 R4 default offset addr", int'(res_addr), 1);
    check("R4 model addr", int'(res_addr), exp_addr(8'h32));
    lookup(8'h31);
    check("R2 R3 miss row3 pos1", int'(res_hit), 0);
    lookup(8'h23);
    check("R2 other row same pos", int'(res_hit), 0);
  endtask

  task automatic t_ignored_writes();
    wr_row(4'd5, 16'hFFFF, 1'b0);
    lookup(8'h50);
    check("R5 bitmap write ignored", int'(res_hit), 0);
    wr_li(4'd3, 9'h040, 1'b0);
    lookup(8'h32);
    check("R5 offset write ignored", int'(res_addr), 1);
  endtask

  task automatic t_latency();
    @(negedge clk);
    lk_valid = 1'b1; lk_key = 8'h30;
    check("R6 no valid before edge", int'(res_valid), 0);
    @(negedge clk);
    lk_valid = 1'b0;
    check("R6 valid one cycle later", int'(res_valid), 1);
    check("R3 hit row3 pos0", int'(res_hit), 1);
    check("R4 addr row3 pos0", int'(res_addr), 0);
    @(negedge clk);
    check("R6 valid drops", int'(res_valid), 0);
    check("R6 hit held", int'(res_hit), 1);
    check("R6 addr held", int'(res_addr), 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    map_en = 1'b1; bm_we = 1'b1; bm_row = 4'd3; bm_data = 16'h0000;
    lk_valid = 1'b1; lk_key = 8'h32;
    @(negedge clk);
    map_en = 1'b0; bm_we = 1'b0; lk_valid = 1'b0;
    check("R7 old contents hit", int'(res_hit), 1);
    check("R7 old contents addr", int'(res_addr), 1);
    m_bm[3] = 16'h0000;
    lookup(8'h32);
    check("R7 new contents seen", int'(res_hit), 0);
  endtask

  task automatic t_wrap();
    wr_row(4'd9, 16'h0007, 1'b1);
    wr_li(4'd9, 9'h1FE, 1'b1);
    lookup(8'h92);
    check("R4 wrap modulo", int'(res_addr), 1);
  endtask

  task automatic t_dense();
    int pre = 0;
    int next = 0;
    for (int r = 0; r < ROWS; r++) begin
      logic [RW-1:0] d;
      d = (r % 5 == 0) ? 16'h0 : (16'(r * 40503) ^ 16'h5A5A);
      wr_row(RS'(r), d, 1'b1);
      wr_li(RS'(r), (W+1)'(pre - 1), 1'b1);
      pre += $countones(d);
    end
    for (int k = 0; k < (1 << W); k++) begin
      logic eh;
      eh = m_bm[k >> P][k % RW];
      lookup(W'(k));
      check("R3 dense hit", int'(res_hit), int'(eh));
      if (eh) begin
        check("R8 dense sequential addr", int'(res_addr), next);
        check("R4 dense formula addr", int'(res_addr), exp_addr(W'(k)));
        next++;
      end
    end
    check("R8 dense total", next, pre);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) begin m_bm[r] = '0; m_li[r] = '1; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_default_offset();
    t_ignored_writes();
    t_latency();
    t_same_cycle();
    t_wrap();
    t_dense();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule